// File: doc/BRIEF.md
# Pulse-Rate Divider with Stall Watchdog

This block turns a slow, irregular pulse train from a rotating machine spindle into a step pulse for a motor driver: one step pulse is produced for every N input pulses, with N set on a ratio input. All logic runs on a free-running system clock. The raw pulse line is never used as a clock. It passes through a synchronizer, and its rising edges become single-cycle events. These events advance a divide counter and feed an inactivity timer.

The step output goes high on the input edge that completes a count. It drops on the next input edge that does not complete a count. When the spindle stops, no further edge arrives to release the output. An inactivity timer therefore counts system-clock cycles since the last input edge. Once the count reaches its limit, the timer pulls the step output low. A stopped machine can thus never leave the motor driver with a step line held high.

Top module: `pulse_rate_divider`

## Requirements
- R1: While `rst_n` is low, `step_out` is low, and it drops as soon as reset is asserted. After reset is released, the first step pulse needs a full count of N input edges.
- R2: With an effective ratio N of 2 or more, `step_out` rises exactly once for every N detected rising edges of `pulse_in`. It rises on the edge that completes each group of N.
- R3: An input edge that does not complete a count drives `step_out` low.
- R4: `step_out` rises on the system-clock edge that follows the edge completing a count. For an input that rises between clocks, this is the `SYNC_STAGES+1`-th clock edge after the rise.
- R5: Once no input edge arrives, a high `step_out` stays high for exactly `TIMEOUT_CYC+1` clock cycles and then falls. Measured from the input rise that set it, it falls on clock edge `SYNC_STAGES+TIMEOUT_CYC+2`.
- R6: A timeout does not reset the divide count. Edges counted before a stall still count toward the next step pulse.
- R7: A `ratio` value of 1 makes every detected edge drive `step_out` high. A value of 0 behaves exactly like 1.
- R8: Only rising edges count. A `pulse_in` held high for any length of time counts as one edge, so a constant high input still lets the timeout release `step_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pulse_in | input | 1 | Raw pulse line from the spindle, asynchronous to `clk` |
| ratio | input | RATIO_W | Divide ratio N (0 is treated as 1), held steady during use |
| step_out | output | 1 | Step pulse to the motor driver |

## Verification
The bench builds the block with a 4-bit ratio, a two-stage synchronizer and a 40-cycle timeout. With these values the bench can sweep every ratio from 0 to 7, plus the largest value 15, with random input gaps. The short timeout keeps stalls, held-high inputs and reset-during-step cases brief, so each can be timed cycle by cycle against the computed latency.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

   // Action applied to the step output register in one cycle
   typedef enum logic [1:0] {
      STEP_HOLD = 2'd0,
      STEP_SET  = 2'd1,
      STEP_DROP = 2'd2
   } step_act_e;

   function automatic int unsigned cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/pdw_edge_sync.sv
module pdw_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_in,
   output logic rise_o
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "pdw_edge_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= raw_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain[LAST];
   end

   assign rise_o = chain[LAST] & ~prev_q;

endmodule

// File: rtl/pdw_ratio_counter.sv
module pdw_ratio_counter #(
   parameter int unsigned RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [RATIO_W-1:0] ratio,
   output logic               fire
);
   generate
      if (RATIO_W < 1) begin : g_bad_width
         $fatal(1, "pdw_ratio_counter needs RATIO_W >= 1");
      end else if (RATIO_W == 1) begin : g_unit
         // Both codes mean a ratio of one: every edge completes a count
         assign fire = tick;
      end else begin : g_count
         localparam int unsigned EXT_W = RATIO_W + 1;

         logic [RATIO_W-1:0] seen_q;
         logic [EXT_W-1:0]   target;
         logic [EXT_W-1:0]   next_seen;
         logic               wrap;

         assign target    = (ratio == '0) ? EXT_W'(1) : {1'b0, ratio};
         assign next_seen = {1'b0, seen_q} + EXT_W'(1);
         assign wrap      = (next_seen >= target);
         assign fire      = tick & wrap;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               seen_q <= '0;
            end else if (tick) begin
               if (wrap) seen_q <= '0;
               else      seen_q <= next_seen[RATIO_W-1:0];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pdw_stall_timer.sv
module pdw_stall_timer #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   output logic stall
);
   import pdw_pkg::*;

   localparam int unsigned CW = cnt_width(LIMIT);
   localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

   logic [CW-1:0] idle_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $fatal(1, "pdw_stall_timer needs LIMIT >= 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_q <= '0;
      end else if (tick) begin
         idle_q <= '0;
      end else if (idle_q != LIM_V) begin
         idle_q <= idle_q + CW'(1);
      end
   end

   assign stall = (idle_q == LIM_V);

endmodule

// File: rtl/pulse_rate_divider.sv
module pulse_rate_divider #(
   parameter int unsigned RATIO_W     = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned TIMEOUT_CYC = 1000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pulse_in,
   input  logic [RATIO_W-1:0] ratio,
   output logic               step_out
);
   import pdw_pkg::*;

   logic      tick;
   logic      fire;
   logic      stall;
   step_act_e act;
   logic      step_q;

   pdw_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_in (pulse_in),
      .rise_o (tick)
   );

   pdw_ratio_counter #(.RATIO_W(RATIO_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .ratio (ratio),
      .fire  (fire)
   );

   pdw_stall_timer #(.LIMIT(TIMEOUT_CYC)) u_wd (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .stall (stall)
   );

   always_comb begin
      if (fire)               act = STEP_SET;
      else if (tick || stall) act = STEP_DROP;
      else                    act = STEP_HOLD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= 1'b0;
      end else begin
         case (act)
            STEP_SET:  step_q <= 1'b1;
            STEP_DROP: step_q <= 1'b0;
            default:   step_q <= step_q;
         endcase
      end
   end

   assign step_out = step_q;

endmodule

// File: rtl/pulse_rate_divider_chk.sv
module pulse_rate_divider_chk #(
   parameter int unsigned RATIO_W     = 8,
   parameter int unsigned TIMEOUT_CYC = 1000
) (
   input logic               clk,
   input logic               rst_n,
   input logic [RATIO_W-1:0] ratio,
   input logic               tick,
   input logic               fire,
   input logic               stall,
   input logic               step_out
);
   localparam int unsigned RUN_MAX = TIMEOUT_CYC + 2;
   localparam int unsigned RW      = $clog2(RUN_MAX + 1);

   logic [RW-1:0] high_run;

   // Cycles the output has stayed high with no input edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      high_run <= '0;
      else if (tick || !step_out)      high_run <= '0;
      else if (high_run != RW'(RUN_MAX)) high_run <= high_run + RW'(1);
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (!step_out);
      end
   end

   p_fire_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> step_out);

   p_plain_edge_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !fire) |=> !step_out);

   p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_out) |-> $past(fire));

   p_stall_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stall && !tick) |=> !step_out);

   p_high_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      high_run <= RW'(TIMEOUT_CYC + 1));

   p_unit_ratio_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && (ratio <= RATIO_W'(1))) |-> fire);

   p_single_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

bind pulse_rate_divider pulse_rate_divider_chk #(
   .RATIO_W     (RATIO_W),
   .TIMEOUT_CYC (TIMEOUT_CYC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ratio    (ratio),
   .tick     (tick),
   .fire     (fire),
   .stall    (stall),
   .step_out (step_out)
);

// File: tb/tb_pulse_rate_divider.sv
module tb_pulse_rate_divider;
   localparam int W = 4;
   localparam int S = 2;
   localparam int T = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pulse_in = 1'b0;
   logic [W-1:0] ratio = '0;
   logic         step_out;

   int tests = 0;
   int fails = 0;
   int rises = 0;
   logic prev_step = 1'b0;
   logic [7:0] lfsr = 8'h5A;

   pulse_rate_divider #(.RATIO_W(W), .SYNC_STAGES(S), .TIMEOUT_CYC(T)) dut (
      .clk(clk), .rst_n(rst_n), .pulse_in(pulse_in), .ratio(ratio), .step_out(step_out)
   );

   always #5 clk = ~clk;

   always @(negedge clk) begin
      if (step_out && !prev_step) rises <= rises + 1;
      prev_step <= step_out;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      pulse_in = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   function automatic int next_gap();
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      return 2 + int'(lfsr[2:0]);
   endfunction

   // Rising input, check step after the latency, then low gap
   task automatic send_pulse(input int hi, input int lo, input bit exp, input string req);
      pulse_in = 1'b1;
      repeat (S + 1) @(negedge clk);
      chk(step_out == exp, req, step_out, exp);
      repeat (hi - (S + 1)) @(negedge clk);
      pulse_in = 1'b0;
      repeat (lo) @(negedge clk);
   endtask

   task automatic sweep(input int r);
      int e;
      int n;
      int base;
      e = (r == 0) ? 1 : r;
      n = 2 * e + 1;
      ratio = W'(r);
      do_reset();
      base = rises;
      for (int k = 1; k <= n; k++) begin
         int gap;
         gap = (e == 1) ? T + 6 : next_gap();
         send_pulse(S + 1 + (k % 3), gap, (k % e) == 0,
                    (e == 1) ? "R7 unit ratio sets" : "R2/R3 level after edge");
      end
      repeat (T + 8) @(negedge clk);
      chk(rises - base == n / e, (e == 1) ? "R7 rise count" : "R2 rise count",
          rises - base, n / e);
      chk(step_out == 1'b0, "R5 low after stall", step_out, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int n;
      int base;

      // R1: idle during and after reset
      ratio = W'(2);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk(step_out == 1'b0, "R1 reset idle", step_out, 0);
      do_reset();
      chk(step_out == 1'b0, "R1 after release", step_out, 0);

      // R2/R3/R7: sweep of ratios, 0 treated as 1
      for (int r = 0; r <= 7; r++) sweep(r);
      sweep(15);

      // R4: exact latency from input rise
      ratio = W'(2);
      do_reset();
      send_pulse(S + 2, 4, 1'b0, "R4 first edge no step");
      pulse_in = 1'b1;
      repeat (S) @(negedge clk);
      chk(step_out == 1'b0, "R4 not before latency", step_out, 0);
      @(negedge clk);
      chk(step_out == 1'b1, "R4 rise at latency", step_out, 1);

      // R5: exact fall time with the input stopped
      n = S + 1;
      for (int i = 0; i < 3 * T; i++) begin
         if (!step_out) break;
         if (n == 5) pulse_in = 1'b0;
         @(negedge clk);
         n++;
      end
      pulse_in = 1'b0;
      chk(n == S + T + 2, "R5 fall cycle", n, S + T + 2);

      // R1: reset while step is high drops it, count restarts
      ratio = W'(2);
      do_reset();
      send_pulse(S + 2, 3, 1'b0, "R1 setup edge 1");
      send_pulse(S + 2, 3, 1'b1, "R1 setup edge 2");
      #2 rst_n = 1'b0;
      #1 chk(step_out == 1'b0, "R1 async drop", step_out, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      send_pulse(S + 2, 3, 1'b0, "R1 count restarted");
      send_pulse(S + 2, 3, 1'b1, "R1 full count after reset");

      // R6: stall keeps the partial count
      ratio = W'(3);
      do_reset();
      send_pulse(S + 2, 3, 1'b0, "R6 edge 1");
      repeat (2 * T) @(negedge clk);
      chk(step_out == 1'b0, "R6 idle during stall", step_out, 0);
      send_pulse(S + 2, 3, 1'b0, "R6 edge 2");
      send_pulse(S + 2, 3, 1'b1, "R6 edge 3 completes");

      // R8: constant high input is one edge and still times out
      ratio = W'(1);
      do_reset();
      base = rises;
      pulse_in = 1'b1;
      repeat (3 * T) @(negedge clk);
      chk(rises - base == 1, "R8 one rise for held level", rises - base, 1);
      chk(step_out == 1'b0, "R8 timeout under held level", step_out, 0);
      pulse_in = 1'b0;
      repeat (3) @(negedge clk);
      send_pulse(S + 2, 3, 1'b1, "R8 new edge after release");

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule